// File: doc/BRIEF.md
# ARP Peer Address Resolver

This block learns the Ethernet address of a single remote peer before any payload traffic is allowed to flow. It takes parsed ARP fields from a receive path that has already done the Ethernet framing. It asks a transmit path to emit ARP frames through a request/done handshake. When the sequence finishes it presents the learned peer MAC and drops its busy flag.

There are two roles, chosen by a mode input. As a requester, the block broadcasts an ARP request and waits for the matching reply. If no reply arrives within the programmed number of clock ticks, it raises a one-cycle interrupt, sets a sticky timeout flag and sends the request again, as many times as needed. As a responder, it waits for the peer's ARP request, learns the peer MAC from it and answers with a unicast ARP reply. It becomes idle only once the transmit path reports that reply as fully sent.

Configuration is captured only when the soft-reset level falls from 1 to 0. Raising soft reset at any point abandons the sequence, holds busy high and clears the timeout flag.

Top module: `arp_resolver`

## Requirements
- R1: After the synchronous reset `rst`, and before soft reset has fallen, `busy`=1, `tx_req`=0, `irq`=0 and `timeout_flag`=0.
- R2: While `soft_rst`=1 the block issues no frame request and keeps `busy`=1. Raising `soft_rst` during a sequence drops `tx_req` on the next cycle, keeps `busy`=1, and no frame follows until `soft_rst` falls again.
- R3: `local_mac`, `local_ip`, `peer_ip`, `mode_responder` and `timeout_val` are sampled only on the clock where `soft_rst` is seen to fall. Later changes to them do not alter any emitted frame field.
- R4: With `mode_responder`=0 the block first requests a frame with opcode 1, destination MAC ff:ff:ff:ff:ff:ff, `tx_ethertype`=0x0806, source MAC and sender IP equal to the local values, target MAC 0 and target IP equal to the peer IP.
- R5: In requester mode, the block looks for a receive beat (`rx_valid`=1) that arrives after the request has been sent. The beat must carry opcode 2, sender IP equal to the peer IP and target IP equal to the local IP. On that beat the block stores `rx_sender_mac` into `peer_mac` and drives `busy` to 0 on the following cycle. After that, `peer_mac` stays unchanged until the next soft reset.
- R6: A receive beat with the wrong opcode, the wrong sender IP or the wrong target IP is ignored. `busy` stays 1 and `peer_mac` keeps its value, which is 0 right after soft reset falls.
- R7: In requester mode, if no matching reply arrives within `timeout_val`+1 cycles after the request is reported sent, `irq` pulses high for exactly one cycle and `timeout_flag` becomes 1 and stays 1.
- R8: Each timeout is followed by a new, identical request. The wait counter reloads from `timeout_val` every time a request is reported sent, so retries repeat until a matching reply arrives.
- R9: With `mode_responder`=1 the block waits for a matching opcode-1 request, where sender IP equals the peer IP and target IP equals the local IP. It learns `rx_sender_mac` and requests a frame with opcode 2, whose destination MAC and target MAC both equal the learned MAC. `busy` stays 1 until `tx_done` is seen, then falls on the next cycle.
- R10: `soft_rst`=1 clears `timeout_flag` on the next cycle.
- R11: Once `tx_req` is high, it and all frame fields stay stable until `tx_done` is seen or `soft_rst` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft-reset level; its falling edge starts resolution |
| mode_responder | input | 1 | 0: send request and wait; 1: wait for request and answer |
| local_mac | input | 48 | Own MAC address |
| local_ip | input | 32 | Own IPv4 address |
| peer_ip | input | 32 | Peer IPv4 address |
| timeout_val | input | 32 | Reply wait limit in clock ticks |
| rx_valid | input | 1 | One-cycle strobe: parsed ARP fields valid |
| rx_opcode | input | 16 | Received ARP opcode |
| rx_sender_mac | input | 48 | Received sender hardware address |
| rx_sender_ip | input | 32 | Received sender protocol address |
| rx_target_ip | input | 32 | Received target protocol address |
| tx_done | input | 1 | Transmit path has fully sent the requested frame |
| tx_req | output | 1 | Frame request, held until tx_done |
| tx_opcode | output | 16 | ARP opcode of requested frame |
| tx_ethertype | output | 16 | EtherType of requested frame |
| tx_dst_mac | output | 48 | Ethernet destination MAC |
| tx_src_mac | output | 48 | Ethernet source / ARP sender MAC |
| tx_sender_ip | output | 32 | ARP sender IP |
| tx_target_mac | output | 48 | ARP target MAC |
| tx_target_ip | output | 32 | ARP target IP |
| peer_mac | output | 48 | Learned peer MAC |
| busy | output | 1 | High until resolution completes |
| irq | output | 1 | One-cycle pulse on reply timeout |
| timeout_flag | output | 1 | Sticky timeout status, cleared by soft reset |

## Verification
The assertions assume that `tx_done` is raised only while `tx_req` is high. They also assume that `rx_valid` is a single-cycle strobe whose fields are meaningful only in that cycle, and that `soft_rst` is a clean level. The bench's model of the transmit path answers only a pending request, two cycles after it appears, and holds `tx_done` for one cycle. Receive beats are driven for one cycle between clock edges, and soft reset changes only on falling clock edges, so every edge sees settled inputs.

// File: rtl/arp_pkg.sv
package arp_pkg;

    localparam int MAC_W = 48;
    localparam int IP_W  = 32;
    localparam int OP_W  = 16;

    localparam logic [OP_W-1:0]  OP_REQUEST = 16'd1;
    localparam logic [OP_W-1:0]  OP_REPLY   = 16'd2;
    localparam logic [15:0]      ETYPE_ARP  = 16'h0806;
    localparam logic [MAC_W-1:0] MAC_BCAST  = {MAC_W{1'b1}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_SEND,
        ST_REQ_WAIT,
        ST_LISTEN,
        ST_REP_SEND,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [OP_W-1:0]  opcode;
        logic [MAC_W-1:0] sender_mac;
        logic [IP_W-1:0]  sender_ip;
        logic [IP_W-1:0]  target_ip;
    } arp_rx_t;

    typedef struct packed {
        logic [OP_W-1:0]  opcode;
        logic [MAC_W-1:0] dst_mac;
        logic [MAC_W-1:0] src_mac;
        logic [IP_W-1:0]  sender_ip;
        logic [MAC_W-1:0] target_mac;
        logic [IP_W-1:0]  target_ip;
    } arp_tx_t;

    typedef struct packed {
        logic [MAC_W-1:0] my_mac;
        logic [IP_W-1:0]  my_ip;
        logic [IP_W-1:0]  far_ip;
        logic             responder;
    } arp_cfg_t;

    function automatic logic addr_pair_ok(input arp_rx_t f,
                                          input logic [IP_W-1:0] mine,
                                          input logic [IP_W-1:0] far);
        return (f.sender_ip == far) && (f.target_ip == mine);
    endfunction

endpackage

// File: rtl/arp_rx_filter.sv
module arp_rx_filter
    import arp_pkg::*;
(
    input  logic            beat,
    input  arp_rx_t         fields,
    input  logic [IP_W-1:0] mine_ip,
    input  logic [IP_W-1:0] far_ip,
    output logic            hit_request,
    output logic            hit_reply
);
    logic pair_ok;

    always_comb begin
        pair_ok     = beat && addr_pair_ok(fields, mine_ip, far_ip);
        hit_request = pair_ok && (fields.opcode == OP_REQUEST);
        hit_reply   = pair_ok && (fields.opcode == OP_REPLY);
    end
endmodule

// File: rtl/arp_retry_timer.sv
module arp_retry_timer #(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [TMO_W-1:0] load_val,
    output logic             expired
);
    logic [TMO_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = run && (remain == '0);

    assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (remain == $past(load_val)));

    assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !load && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/arp_seq_ctrl.sv
module arp_seq_ctrl
    import arp_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  arp_cfg_t         cfg_in,
    input  logic [TMO_W-1:0] tmo_in,
    input  logic             hit_request,
    input  logic             hit_reply,
    input  logic [MAC_W-1:0] rx_mac,
    input  logic             tx_done,
    input  logic             expired,
    output seq_state_e       state,
    output arp_cfg_t         cfg,
    output logic [TMO_W-1:0] tmo_cfg,
    output logic [MAC_W-1:0] learned_mac,
    output logic             timer_load,
    output logic             timer_run,
    output logic             busy,
    output logic             irq,
    output logic             timeout_flag
);
    logic srst_q;
    logic start;

    assign start = srst_q && !soft_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            srst_q       <= 1'b1;
            cfg          <= '0;
            tmo_cfg      <= '0;
            learned_mac  <= '0;
            irq          <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            srst_q <= soft_rst;
            irq    <= 1'b0;
            if (soft_rst) begin
                state        <= ST_IDLE;
                timeout_flag <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (start) begin
                            cfg         <= cfg_in;
                            tmo_cfg     <= tmo_in;
                            learned_mac <= '0;
                            state       <= cfg_in.responder ? ST_LISTEN : ST_REQ_SEND;
                        end
                    end
                    ST_REQ_SEND: begin
                        if (tx_done) state <= ST_REQ_WAIT;
                    end
                    ST_REQ_WAIT: begin
                        if (hit_reply) begin
                            learned_mac <= rx_mac;
                            state       <= ST_DONE;
                        end else if (expired) begin
                            irq          <= 1'b1;
                            timeout_flag <= 1'b1;
                            state        <= ST_REQ_SEND;
                        end
                    end
                    ST_LISTEN: begin
                        if (hit_request) begin
                            learned_mac <= rx_mac;
                            state       <= ST_REP_SEND;
                        end
                    end
                    ST_REP_SEND: begin
                        if (tx_done) state <= ST_DONE;
                    end
                    ST_DONE: state <= ST_DONE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign timer_load = (state == ST_REQ_SEND) && tx_done;
    assign timer_run  = (state == ST_REQ_WAIT);
    assign busy       = (state != ST_DONE);

    assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> timeout_flag);

    assert_flag_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !timeout_flag);

    assert_learned_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !soft_rst) |=> $stable(learned_mac));

    assert_retry_after_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !soft_rst) |-> (state == ST_REQ_SEND));
endmodule

// File: rtl/arp_tx_format.sv
module arp_tx_format
    import arp_pkg::*;
(
    input  seq_state_e       state,
    input  arp_cfg_t         cfg,
    input  logic [MAC_W-1:0] learned_mac,
    output logic             req,
    output arp_tx_t          frame
);
    always_comb begin
        req   = 1'b0;
        frame = '0;
        if (state == ST_REQ_SEND || state == ST_REP_SEND) begin
            req             = 1'b1;
            frame.src_mac   = cfg.my_mac;
            frame.sender_ip = cfg.my_ip;
            frame.target_ip = cfg.far_ip;
            if (state == ST_REQ_SEND) begin
                frame.opcode     = OP_REQUEST;
                frame.dst_mac    = MAC_BCAST;
                frame.target_mac = '0;
            end else begin
                frame.opcode     = OP_REPLY;
                frame.dst_mac    = learned_mac;
                frame.target_mac = learned_mac;
            end
        end
    end
endmodule

// File: rtl/arp_resolver.sv
module arp_resolver
    import arp_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             mode_responder,
    input  logic [47:0]      local_mac,
    input  logic [31:0]      local_ip,
    input  logic [31:0]      peer_ip,
    input  logic [TMO_W-1:0] timeout_val,
    input  logic             rx_valid,
    input  logic [15:0]      rx_opcode,
    input  logic [47:0]      rx_sender_mac,
    input  logic [31:0]      rx_sender_ip,
    input  logic [31:0]      rx_target_ip,
    input  logic             tx_done,
    output logic             tx_req,
    output logic [15:0]      tx_opcode,
    output logic [15:0]      tx_ethertype,
    output logic [47:0]      tx_dst_mac,
    output logic [47:0]      tx_src_mac,
    output logic [31:0]      tx_sender_ip,
    output logic [47:0]      tx_target_mac,
    output logic [31:0]      tx_target_ip,
    output logic [47:0]      peer_mac,
    output logic             busy,
    output logic             irq,
    output logic             timeout_flag
);
    arp_rx_t          rx_f;
    arp_cfg_t         cfg_in, cfg;
    arp_tx_t          frame;
    seq_state_e       state;
    logic [TMO_W-1:0] tmo_cfg;
    logic             hit_request, hit_reply;
    logic             timer_load, timer_run, expired;

    assign rx_f   = '{opcode: rx_opcode, sender_mac: rx_sender_mac,
                      sender_ip: rx_sender_ip, target_ip: rx_target_ip};
    assign cfg_in = '{my_mac: local_mac, my_ip: local_ip,
                      far_ip: peer_ip, responder: mode_responder};

    arp_rx_filter u_filter (
        .beat        (rx_valid),
        .fields      (rx_f),
        .mine_ip     (cfg.my_ip),
        .far_ip      (cfg.far_ip),
        .hit_request (hit_request),
        .hit_reply   (hit_reply)
    );

    arp_seq_ctrl #(.TMO_W(TMO_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .cfg_in       (cfg_in),
        .tmo_in       (timeout_val),
        .hit_request  (hit_request),
        .hit_reply    (hit_reply),
        .rx_mac       (rx_sender_mac),
        .tx_done      (tx_done),
        .expired      (expired),
        .state        (state),
        .cfg          (cfg),
        .tmo_cfg      (tmo_cfg),
        .learned_mac  (peer_mac),
        .timer_load   (timer_load),
        .timer_run    (timer_run),
        .busy         (busy),
        .irq          (irq),
        .timeout_flag (timeout_flag)
    );

    arp_retry_timer #(.TMO_W(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .run      (timer_run),
        .load_val (tmo_cfg),
        .expired  (expired)
    );

    arp_tx_format u_fmt (
        .state       (state),
        .cfg         (cfg),
        .learned_mac (peer_mac),
        .req         (tx_req),
        .frame       (frame)
    );

    assign tx_opcode     = frame.opcode;
    assign tx_ethertype  = tx_req ? ETYPE_ARP : 16'h0000;
    assign tx_dst_mac    = frame.dst_mac;
    assign tx_src_mac    = frame.src_mac;
    assign tx_sender_ip  = frame.sender_ip;
    assign tx_target_mac = frame.target_mac;
    assign tx_target_ip  = frame.target_ip;

    assert_abort_R2: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (busy && !tx_req));

    assert_idle_no_frame_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_req);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done && !soft_rst) |=>
            (tx_req && $stable(tx_opcode) && $stable(tx_dst_mac) &&
             $stable(tx_target_mac) && $stable(tx_target_ip)));

    assert_ethertype_R4: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (tx_ethertype == 16'h0806));
endmodule

// File: tb/arp_resolver_tb_top.sv
module arp_resolver_tb_top;

    typedef struct packed {
        logic [15:0] op;
        logic [47:0] dst;
        logic [47:0] src;
        logic [31:0] sip;
        logic [47:0] tmac;
        logic [31:0] tip;
    } exp_frame_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b1;
    logic        mode_responder = 1'b0;
    logic [47:0] local_mac = '0;
    logic [31:0] local_ip = '0, peer_ip = '0, timeout_val = 32'd1000;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_opcode = '0;
    logic [47:0] rx_sender_mac = '0;
    logic [31:0] rx_sender_ip = '0, rx_target_ip = '0;
    logic        tx_done = 1'b0;
    logic        tx_req, busy, irq, timeout_flag;
    logic [15:0] tx_opcode, tx_ethertype;
    logic [47:0] tx_dst_mac, tx_src_mac, tx_target_mac, peer_mac;
    logic [31:0] tx_sender_ip, tx_target_ip;

    int compared = 0, mismatched = 0;
    int acks = 0, reqs_seen = 0, irqs = 0;
    bit ack_en = 1'b1;
    exp_frame_t exp_q[$];

    always #4 clk = ~clk;

    arp_resolver dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] op, input logic [47:0] dst, input logic [47:0] src,
                            input logic [31:0] sip, input logic [47:0] tmac, input logic [31:0] tip);
        exp_frame_t e;
        e = '{op: op, dst: dst, src: src, sip: sip, tmac: tmac, tip: tip};
        exp_q.push_back(e);
    endtask

    task automatic send_rx(input logic [15:0] op, input logic [47:0] mac,
                           input logic [31:0] sip, input logic [31:0] tip);
        @(negedge clk);
        rx_valid = 1'b1; rx_opcode = op; rx_sender_mac = mac;
        rx_sender_ip = sip; rx_target_ip = tip;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_acks(input int n);
        while (acks < n) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: scoreboard compare on each new frame request
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (irq) irqs++;
            if (tx_req && !prev) begin
                exp_frame_t got, e;
                reqs_seen++;
                got = '{op: tx_opcode, dst: tx_dst_mac, src: tx_src_mac,
                        sip: tx_sender_ip, tmac: tx_target_mac, tip: tx_target_ip};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R9 unexpected frame", 64'(got.op), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(got == e, "R4/R9/R3 frame fields", 64'(got.dst ^ got.tmac), 64'(e.dst ^ e.tmac));
                    check(got.op == e.op, "R4/R9 opcode", 64'(got.op), 64'(e.op));
                end
                check(tx_ethertype == 16'h0806, "R4 ethertype", 64'(tx_ethertype), 64'h0806);
            end
            prev = tx_req;
        end
    end

    // Transmit path model: completes a pending request after two cycles
    initial begin
        forever begin
            @(negedge clk);
            if (tx_req && ack_en) begin
                repeat (2) @(negedge clk);
                if (tx_req) begin
                    tx_done = 1'b1;
                    @(negedge clk);
                    tx_done = 1'b0;
                    acks++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [47:0] lm_a = 48'h02_11_22_33_44_55, pm_a = 48'h02_aa_bb_cc_dd_ee;
        logic [31:0] li_a = 32'hc0a8_0001, pi_a = 32'hc0a8_0002;
        int base;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy && !tx_req && !irq && !timeout_flag, "R1 reset state",
              {60'd0, busy, tx_req, irq, timeout_flag}, 64'b1000);
        repeat (5) @(negedge clk);
        check(!tx_req && busy, "R2 held soft reset quiet", {62'd0, tx_req, busy}, 64'b01);

        // Requester run
        local_mac = lm_a; local_ip = li_a; peer_ip = pi_a; mode_responder = 1'b0; timeout_val = 32'd1000;
        push_exp(16'd1, 48'hffff_ffff_ffff, lm_a, li_a, 48'd0, pi_a);
        soft_rst = 1'b0;
        @(negedge clk);
        local_mac = 48'h0; local_ip = 32'h1; peer_ip = 32'h2; mode_responder = 1'b1; // R3 ignored
        wait_acks(1);
        send_rx(16'd2, pm_a, 32'h0a00_0009, li_a);   // wrong sender ip
        @(negedge clk);
        check(busy && peer_mac == 48'd0, "R6 wrong sender ip ignored", 64'(peer_mac), 64'd0);
        send_rx(16'd1, pm_a, pi_a, li_a);            // wrong opcode
        @(negedge clk);
        check(busy && peer_mac == 48'd0, "R6 wrong opcode ignored", 64'(peer_mac), 64'd0);
        send_rx(16'd2, pm_a, pi_a, 32'h0a00_0001);   // wrong target ip
        @(negedge clk);
        check(busy, "R6 wrong target ip ignored", 64'(busy), 64'd1);
        send_rx(16'd2, pm_a, pi_a, li_a);
        check(!busy, "R5 busy drops after reply", 64'(busy), 64'd0);
        check(peer_mac == pm_a, "R5 learned mac", 64'(peer_mac), 64'(pm_a));
        check(!timeout_flag && irqs == 0, "R7 no timeout yet", 64'(irqs), 64'd0);
        repeat (5) @(negedge clk);
        check(peer_mac == pm_a && !busy, "R5 learned mac holds", 64'(peer_mac), 64'(pm_a));

        // Timeout and retry
        soft_rst = 1'b1;
        @(negedge clk);
        local_mac = lm_a; local_ip = li_a; peer_ip = pi_a; mode_responder = 1'b0; timeout_val = 32'd20;
        for (int k = 0; k < 4; k++) push_exp(16'd1, 48'hffff_ffff_ffff, lm_a, li_a, 48'd0, pi_a);
        base = reqs_seen;
        acks = 0; irqs = 0;
        soft_rst = 1'b0;
        wait_acks(1);
        repeat (18) @(negedge clk);
        check(irqs == 0 && busy, "R7 no irq inside window", 64'(irqs), 64'd0);
        while (irqs < 3) @(negedge clk);
        check(timeout_flag, "R7 sticky timeout flag", 64'(timeout_flag), 64'd1);
        @(negedge clk);
        check(!irq, "R7 irq one cycle", 64'(irq), 64'd0);
        wait_acks(4);
        check(reqs_seen - base == 4, "R8 request resent per timeout", 64'(reqs_seen - base), 64'd4);
        send_rx(16'd2, pm_a, pi_a, li_a);
        check(!busy && peer_mac == pm_a, "R8 reply after retries", 64'(peer_mac), 64'(pm_a));
        check(timeout_flag, "R7 flag stays after success", 64'(timeout_flag), 64'd1);
        soft_rst = 1'b1;
        @(negedge clk);
        check(!timeout_flag && busy, "R10 soft reset clears flag", 64'(timeout_flag), 64'd0);

        // Responder run
        mode_responder = 1'b1; timeout_val = 32'd5;
        ack_en = 1'b0;
        push_exp(16'd2, pm_a, lm_a, li_a, pm_a, pi_a);
        acks = 0;
        soft_rst = 1'b0;
        repeat (30) @(negedge clk);
        check(!tx_req && busy && irqs == 3, "R9 responder waits silently", 64'(tx_req), 64'd0);
        send_rx(16'd1, pm_a, pi_a, 32'h0a0a_0a0a);
        @(negedge clk);
        check(!tx_req && busy, "R6 responder ignores other target", 64'(tx_req), 64'd0);
        send_rx(16'd1, pm_a, pi_a, li_a);
        repeat (6) @(negedge clk);
        check(tx_req && busy && tx_opcode == 16'd2, "R11 reply held until done", 64'(tx_opcode), 64'd2);
        ack_en = 1'b1;
        wait_acks(1);
        check(!busy && peer_mac == pm_a, "R9 idle after reply sent", 64'(busy), 64'd0);

        // Abort mid-sequence
        soft_rst = 1'b1;
        @(negedge clk);
        mode_responder = 1'b0; ack_en = 1'b0;
        push_exp(16'd1, 48'hffff_ffff_ffff, lm_a, li_a, 48'd0, pi_a);
        soft_rst = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_req, "R4 request pending", 64'(tx_req), 64'd1);
        soft_rst = 1'b1;
        @(negedge clk);
        check(!tx_req && busy, "R2 abort to idle", {62'd0, tx_req, busy}, 64'b01);
        repeat (5) @(negedge clk);
        check(!tx_req && busy, "R2 stays idle in soft reset", 64'(tx_req), 64'd0);
        check(exp_q.size() == 0, "R11 scoreboard drained", 64'(exp_q.size()), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule